// File: doc/BRIEF.md
# Multicycle Stored-Program Control Unit

A small 16-bit processor core that handles each instruction as a chain of phases, with one clock per step. The phases are fetch, decode, evaluate address, fetch operands, execute and store result. A phase that the opcode does not need is skipped. The core holds a program counter, an instruction register and eight general registers.

All memory traffic passes through two staging registers: an address latch that drives the address bus and a data latch that drives the write bus and catches read data. The memory is single-port and synchronous. Its read data arrives one cycle after the read strobe.

The core executes register add, AND and complement, load and store at base plus offset, and an unconditional jump to a register plus an offset. A halt input freezes every register in place and masks both strobes, so the core resumes exactly where it stopped.

Top module: `mc_core`

## Requirements
- R1: After synchronous reset the core is in the fetch phase. The program counter and all eight general registers read zero, and both memory strobes are low.
- R2: Fetch runs in this order:
  - The program counter is copied into the address latch.
  - The read strobe is high for one cycle with that address.
  - One cycle later the returned word is captured into the data latch.
  - The data latch is copied into the instruction register and the program counter is incremented by 1.
  - Decode follows four cycles after fetch begins.
  - On `phase_o`: fetch=0, decode=1, evaluate address=2, operand=3, execute=4, store=5.
- R3: The opcode sits in bits [15:12], and the core executes only these encodings: ADD=0001, AND=0101, NOT=1001, LDR=0110, STR=0111, JMP=1100. Any other opcode changes no register and no memory, and the next fetch follows.
- R4: ADD and AND write R[11:9] with R[8:6] combined with R[2:0]. The sum wraps modulo 2^16.
- R5: NOT writes R[11:9] with the bitwise complement of R[8:6].
- R6: LDR reads the word at R[8:6] plus the sign-extended offset in bits [5:0], and writes it to R[11:9].
- R7: STR writes R[11:9] to R[8:6] plus the sign-extended offset [5:0]. The data latch is loaded first, then the address latch, and only then is the write strobe raised.
- R8: JMP loads the program counter with R[8:6] plus the sign-extended offset [5:0], unconditionally. The word after the jump is not executed.
- R9: Instruction length, counted from fetch start to the next fetch start:
  - ADD, AND and NOT take 8 cycles.
  - LDR takes 10 cycles.
  - STR takes 9 cycles.
  - JMP takes 7 cycles.
  - An undefined opcode takes 5 cycles.
- R10: While `halt` is high, no register or state changes, and both strobes are low. After release, execution continues with the same results.
- R11: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Freeze enable; high stops all progress |
| mem_rdata | input | 16 | Read data, valid one cycle after the read strobe |
| mem_addr | output | 16 | Address latch contents |
| mem_wdata | output | 16 | Data latch contents |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| pc_o | output | 16 | Program counter |
| phase_o | output | 3 | Current phase code |

## Verification
The bench measures the gap between successive instruction fetches for each opcode class. A sequencer that visits an unneeded phase, or drops the read wait state, shifts these counts.

On every write it checks that the data bus settled a cycle before the address moved. A store that swaps the staging order would show the old address paired with the new strobe.

Negative offsets on load, store and jump are exercised, together with a skipped word after the jump. A zero-extending offset or a conditional jump would corrupt the sentinel words.

Undefined opcodes and a mid-instruction halt must leave memory and progress untouched, which catches a core that partially commits or drifts while frozen.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_NOT = 4'b1001;
  localparam logic [3:0] OPC_LDR = 4'b0110;
  localparam logic [3:0] OPC_STR = 4'b0111;
  localparam logic [3:0] OPC_JMP = 4'b1100;

  typedef enum logic [3:0] {
    S_F_MAR, S_F_RD, S_F_WAIT, S_F_IR,
    S_DEC,
    S_EA,
    S_OP_MAR, S_OP_RD, S_OP_WAIT, S_OP_REG,
    S_EX,
    S_ST_MDR, S_ST_MAR, S_ST_WR, S_ST_REG, S_ST_PC
  } state_t;

  typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_NOT} alu_op_t;

  function automatic logic [2:0] phase_of(state_t s);
    case (s)
      S_F_MAR, S_F_RD, S_F_WAIT, S_F_IR:       return 3'd0;
      S_DEC:                                   return 3'd1;
      S_EA:                                    return 3'd2;
      S_OP_MAR, S_OP_RD, S_OP_WAIT, S_OP_REG:  return 3'd3;
      S_EX:                                    return 3'd4;
      default:                                 return 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/mc_opdec.sv
module mc_opdec #(
  parameter int OPW = 4
) (
  input  logic [OPW-1:0]      op,
  output logic [2**OPW-1:0]   hot
);
  localparam int NLINES = 2**OPW;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    assign hot[g] = (op == OPW'(g));
  end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W    = 16,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [W-1:0]            wdata,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [W-1:0]            rd1,
  output logic [W-1:0]            rd2
);
  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign rd1 = regs_q[ra1];
  assign rd2 = regs_q[ra2];

endmodule

// File: rtl/mc_alu.sv
module mc_alu #(
  parameter int W = 16
) (
  input  mc_pkg::alu_op_t sel,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y
);
  import mc_pkg::*;

  always_comb begin
    case (sel)
      ALU_ADD: y = a + b;
      ALU_AND: y = a & b;
      default: y = ~a;
    endcase
  end

endmodule

// File: rtl/mc_core.sv
module mc_core #(
  parameter int W    = 16,
  parameter int NREG = 8,
  parameter int OFFW = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         halt,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_rd,
  output logic         mem_wr,
  output logic [W-1:0] pc_o,
  output logic [2:0]   phase_o
);
  import mc_pkg::*;

  localparam int RW    = $clog2(NREG);
  localparam int OPW   = 4;
  localparam int NOPS  = 2**OPW;
  localparam logic [NOPS-1:0] LEGAL_MASK =
    (NOPS'(1) << OPC_ADD) | (NOPS'(1) << OPC_AND) | (NOPS'(1) << OPC_NOT) |
    (NOPS'(1) << OPC_LDR) | (NOPS'(1) << OPC_STR) | (NOPS'(1) << OPC_JMP);

  state_t       st_q, st_d;
  logic [W-1:0] pc_q, ir_q, mar_q, mdr_q, ea_q, opa_q, opb_q, res_q;
  logic         en;
  logic [NOPS-1:0] hot;
  logic         is_add, is_and, is_not, is_ldr, is_str, is_jmp, is_alu, legal;
  logic [RW-1:0] f_dst, f_src1, f_src2, ra2;
  logic [W-1:0] off_ext, rd1, rd2, alu_y, wb_data;
  logic         rf_we;
  alu_op_t      alu_sel;

  assign en = !halt;

  // opcode decode
  mc_opdec #(.OPW(OPW)) u_dec (.op(ir_q[W-1 -: OPW]), .hot(hot));

  assign is_add = hot[OPC_ADD];
  assign is_and = hot[OPC_AND];
  assign is_not = hot[OPC_NOT];
  assign is_ldr = hot[OPC_LDR];
  assign is_str = hot[OPC_STR];
  assign is_jmp = hot[OPC_JMP];
  assign is_alu = is_add | is_and | is_not;
  assign legal  = |(hot & LEGAL_MASK);

  assign f_dst   = ir_q[11:9];
  assign f_src1  = ir_q[8:6];
  assign f_src2  = ir_q[2:0];
  assign off_ext = {{(W-OFFW){ir_q[OFFW-1]}}, ir_q[OFFW-1:0]};

  // second read port supplies the store source during data staging
  assign ra2     = (st_q == S_ST_MDR) ? f_dst : f_src2;
  assign rf_we   = en && (st_q == S_ST_REG);
  assign wb_data = is_ldr ? mdr_q : res_q;

  mc_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(f_dst), .wdata(wb_data),
    .ra1(f_src1), .ra2(ra2), .rd1(rd1), .rd2(rd2)
  );

  assign alu_sel = is_add ? ALU_ADD : (is_and ? ALU_AND : ALU_NOT);

  mc_alu #(.W(W)) u_alu (.sel(alu_sel), .a(opa_q), .b(opb_q), .y(alu_y));

  // phase sequencer
  always_comb begin
    st_d = st_q;
    case (st_q)
      S_F_MAR:   st_d = S_F_RD;
      S_F_RD:    st_d = S_F_WAIT;
      S_F_WAIT:  st_d = S_F_IR;
      S_F_IR:    st_d = S_DEC;
      S_DEC:     st_d = !legal ? S_F_MAR : (is_alu ? S_OP_REG : S_EA);
      S_EA:      st_d = is_ldr ? S_OP_MAR : (is_str ? S_ST_MDR : S_ST_PC);
      S_OP_MAR:  st_d = S_OP_RD;
      S_OP_RD:   st_d = S_OP_WAIT;
      S_OP_WAIT: st_d = S_ST_REG;
      S_OP_REG:  st_d = S_EX;
      S_EX:      st_d = S_ST_REG;
      S_ST_MDR:  st_d = S_ST_MAR;
      S_ST_MAR:  st_d = S_ST_WR;
      default:   st_d = S_F_MAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= S_F_MAR;
      pc_q  <= '0;
      ir_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ea_q  <= '0;
      opa_q <= '0;
      opb_q <= '0;
      res_q <= '0;
    end else if (en) begin
      st_q <= st_d;
      case (st_q)
        S_F_MAR:             mar_q <= pc_q;
        S_F_WAIT, S_OP_WAIT: mdr_q <= mem_rdata;
        S_F_IR: begin
          ir_q <= mdr_q;
          pc_q <= pc_q + W'(1);
        end
        S_EA:     ea_q  <= rd1 + off_ext;
        S_OP_MAR: mar_q <= ea_q;
        S_OP_REG: begin
          opa_q <= rd1;
          opb_q <= rd2;
        end
        S_EX:     res_q <= alu_y;
        S_ST_MDR: mdr_q <= rd2;
        S_ST_MAR: mar_q <= ea_q;
        S_ST_PC:  pc_q  <= ea_q;
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_rd    = en && ((st_q == S_F_RD) || (st_q == S_OP_RD));
  assign mem_wr    = en && (st_q == S_ST_WR);
  assign pc_o      = pc_q;
  assign phase_o   = phase_of(st_q);

  // assertions
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_halt_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    halt |=> ($stable(pc_q) && $stable(st_q) && $stable(ir_q) &&
              $stable(mar_q) && $stable(mdr_q)));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(st_q) == S_F_IR && !$past(halt)) |-> (pc_q == $past(pc_q) + W'(1)));

  p_ir_only_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(ir_q) |-> ($past(st_q) == S_F_IR));

  p_wr_addr_staged_r7: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_addr == ea_q));

  p_jump_target_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(st_q) == S_ST_PC && !$past(halt)) |-> (pc_q == $past(ea_q)));

endmodule

// File: tb/mc_core_tb.sv
`timescale 1ns/1ps
module mc_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt = 1'b0;
  logic [15:0] mem_rdata;
  logic [15:0] mem_addr, mem_wdata, pc_o;
  logic        mem_rd, mem_wr;
  logic [2:0]  phase_o;

  always #2 clk = ~clk;

  mc_core dut_i (
    .clk(clk), .rst(rst), .halt(halt), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .pc_o(pc_o), .phase_o(phase_o)
  );

  // synchronous memory model, one cycle read latency
  logic [15:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;
  int first_rd  [0:255];
  int second_rd [0:255];
  logic [15:0] prev_addr, prev_wdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus monitor
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (mem_rd) begin
        if (first_rd[mem_addr[7:0]] < 0) first_rd[mem_addr[7:0]] = cyc;
        else if (second_rd[mem_addr[7:0]] < 0) second_rd[mem_addr[7:0]] = cyc;
      end
      if (mem_wr) begin
        chk(prev_wdata == mem_wdata, "R7 data staged before address", prev_wdata, mem_wdata);
        chk(prev_addr != mem_addr, "R7 address staged after data", prev_addr, mem_addr);
      end
      if (mem_rd && mem_wr) chk(0, "R11 strobes overlap", 1, 0);
      if (halt && (mem_rd || mem_wr)) chk(0, "R10 strobe while halted", {mem_rd, mem_wr}, 0);
    end
    prev_addr  = mem_addr;
    prev_wdata = mem_wdata;
  end

  function automatic logic [15:0] e_rrr(logic [3:0] op, int d, int s1, int s2);
    return {op, d[2:0], s1[2:0], 3'b000, s2[2:0]};
  endfunction
  function automatic logic [15:0] e_mem(logic [3:0] op, int d, int b, int off);
    return {op, d[2:0], b[2:0], off[5:0]};
  endfunction
  function automatic logic [15:0] e_not(int d, int s);
    return {4'b1001, d[2:0], s[2:0], 6'h3F};
  endfunction
  function automatic logic [15:0] e_jmp(int b, int off);
    return {4'b1100, 3'b000, b[2:0], off[5:0]};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'h0000;
      first_rd[i] = -1;
      second_rd[i] = -1;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    halt = 1'b0;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 256; i++) begin
      first_rd[i] = -1;
      second_rd[i] = -1;
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_prog_a();
    clear_mem();
    mem[16] = 16'h1234;
    mem[17] = 16'h0F0F;
    mem[23] = 16'hDEAD;
    mem[0] = e_mem(4'b0110, 1, 0, 16);
    mem[1] = e_mem(4'b0110, 2, 0, 17);
    mem[2] = e_rrr(4'b0001, 3, 1, 2);
    mem[3] = e_rrr(4'b0101, 4, 1, 2);
    mem[4] = e_not(5, 1);
    mem[5] = e_mem(4'b0111, 3, 0, 20);
    mem[6] = e_mem(4'b0111, 4, 0, 21);
    mem[7] = e_mem(4'b0111, 5, 0, 22);
    mem[8] = e_mem(4'b0111, 6, 0, 23);
    mem[9] = e_jmp(0, 9);
  endtask

  task automatic check_prog_a(input string tag);
    chk(mem[20] == 16'h2143, {tag, " R4 add"}, mem[20], 16'h2143);
    chk(mem[21] == 16'h0204, {tag, " R4 and"}, mem[21], 16'h0204);
    chk(mem[22] == 16'hEDCB, {tag, " R5 not"}, mem[22], 16'hEDCB);
    chk(mem[23] == 16'h0000, {tag, " R1 unwritten reg reads zero"}, mem[23], 0);
  endtask

  // reset state, fetch order, ALU ops, timing per class
  task automatic t_basic();
    load_prog_a();
    do_reset();
    chk(pc_o == 0, "R1 pc after reset", pc_o, 0);
    chk(phase_o == 0, "R1 phase after reset", phase_o, 0);
    chk(!mem_rd && !mem_wr, "R1 strobes after reset", {mem_rd, mem_wr}, 0);
    @(negedge clk);
    chk(mem_rd && mem_addr == 0, "R2 read strobe with pc address", {mem_rd, mem_addr}, {1'b1, 16'h0});
    @(negedge clk);
    chk(!mem_rd, "R2 single read cycle", mem_rd, 0);
    @(negedge clk);
    chk(pc_o == 0 && phase_o == 0, "R2 still fetching", {phase_o, pc_o}, 0);
    @(negedge clk);
    chk(pc_o == 1 && phase_o == 1, "R2 decode with pc+1", {phase_o, pc_o}, {3'd1, 16'd1});
    repeat (110) @(negedge clk);
    check_prog_a("basic");
    chk(first_rd[1] - first_rd[0] == 10, "R9 ldr length", first_rd[1] - first_rd[0], 10);
    chk(first_rd[3] - first_rd[2] == 8, "R9 add length", first_rd[3] - first_rd[2], 8);
    chk(first_rd[4] - first_rd[3] == 8, "R9 and length", first_rd[4] - first_rd[3], 8);
    chk(first_rd[5] - first_rd[4] == 8, "R9 not length", first_rd[5] - first_rd[4], 8);
    chk(first_rd[6] - first_rd[5] == 9, "R9 str length", first_rd[6] - first_rd[5], 9);
    chk(second_rd[9] - first_rd[9] == 7, "R9 jmp length", second_rd[9] - first_rd[9], 7);
    chk(first_rd[16] - first_rd[0] == 6, "R6 load read issued in operand phase", first_rd[16] - first_rd[0], 6);
  endtask

  // negative offsets and jump
  task automatic t_signext();
    clear_mem();
    mem[16] = 16'h0030;
    mem[17] = 16'hABCD;
    mem[27] = 16'h5555;
    mem[0] = e_mem(4'b0110, 1, 0, 16);
    mem[1] = e_mem(4'b0111, 1, 1, -1);
    mem[2] = e_mem(4'b0110, 2, 1, -31);
    mem[3] = e_mem(4'b0111, 2, 0, 25);
    mem[4] = e_jmp(1, -8);
    mem[5] = e_mem(4'b0111, 2, 0, 27);
    mem[8'h28] = e_mem(4'b0111, 1, 0, 26);
    mem[8'h29] = e_jmp(1, -7);
    do_reset();
    repeat (120) @(negedge clk);
    chk(mem[8'h2F] == 16'h0030, "R7 store negative offset", mem[8'h2F], 16'h0030);
    chk(mem[25] == 16'hABCD, "R6 load negative offset", mem[25], 16'hABCD);
    chk(mem[26] == 16'h0030, "R8 jump target executed", mem[26], 16'h0030);
    chk(mem[27] == 16'h5555, "R8 word after jump skipped", mem[27], 16'h5555);
    chk(first_rd[5] < 0, "R8 word after jump never fetched", first_rd[5], -1);
    chk(pc_o == 16'h29 || pc_o == 16'h2A, "R8 pc in jump loop", pc_o, 16'h29);
  endtask

  // undefined opcodes, add wrap
  task automatic t_undef();
    clear_mem();
    mem[16] = 16'hFFFF;
    mem[17] = 16'h0002;
    mem[0] = e_mem(4'b0110, 1, 0, 16);
    mem[1] = e_mem(4'b0110, 2, 0, 17);
    mem[2] = 16'hF27F;
    mem[3] = e_rrr(4'b0001, 3, 1, 2);
    mem[4] = e_mem(4'b0111, 3, 0, 20);
    mem[5] = e_mem(4'b0111, 1, 0, 21);
    mem[6] = 16'h2E3F;
    mem[7] = e_mem(4'b0111, 2, 0, 22);
    mem[8] = e_jmp(0, 8);
    do_reset();
    repeat (110) @(negedge clk);
    chk(mem[20] == 16'h0001, "R4 add wraps", mem[20], 16'h0001);
    chk(mem[21] == 16'hFFFF, "R3 undefined opcode leaves register", mem[21], 16'hFFFF);
    chk(mem[22] == 16'h0002, "R3 undefined opcode leaves register 2", mem[22], 16'h0002);
    chk(mem[8'h3F] == 0 && mem[8'h2F] == 0, "R3 undefined opcode no store", {mem[8'h3F], mem[8'h2F]}, 0);
    chk(first_rd[3] - first_rd[2] == 5, "R9 undefined length", first_rd[3] - first_rd[2], 5);
    chk(first_rd[7] - first_rd[6] == 5, "R9 undefined length 2", first_rd[7] - first_rd[6], 5);
  endtask

  // halt mid-instruction
  task automatic t_halt();
    logic [15:0] s_pc, s_addr, s_wd;
    logic [2:0]  s_ph;
    bit          moved;
    load_prog_a();
    do_reset();
    repeat (14) @(negedge clk);
    halt = 1'b1;
    s_pc = pc_o; s_addr = mem_addr; s_wd = mem_wdata; s_ph = phase_o;
    moved = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (pc_o != s_pc || mem_addr != s_addr || mem_wdata != s_wd || phase_o != s_ph ||
          mem_rd || mem_wr) moved = 1;
    end
    chk(!moved, "R10 frozen while halted", moved, 0);
    halt = 1'b0;
    repeat (120) @(negedge clk);
    check_prog_a("halt");
  endtask

  initial begin
    clear_mem();
    t_basic();
    t_signext();
    t_undef();
    t_halt();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule